// File: doc/BRIEF.md
# Framed Serial Word Parity Checker

This block takes a stream of data bits, one bit per clock, and groups them into words of four bits each. It keeps a running odd/even record of the ones seen in the current word. When the fourth bit of a word is presented, it reports in that same cycle whether the complete word held an odd number of ones, and it raises a strobe that marks the end of the word. It then starts the next word at once, so words can follow each other with no idle cycle between them.

The input side is a valid-qualified stream. A bit is taken only in a cycle where `bit_valid` is high. The block has no back-pressure path and accepts every valid bit in the cycle it is offered. A cycle with `bit_valid` low is a stall: the position in the word and the partial parity stay as they are, and whatever is on `bit_in` is ignored. The two results are Mealy outputs. They depend on the bit presented in the current cycle and are valid only while `word_done` is high. A synchronous reset abandons any partial word.

Top module: `serial_word_parity`

## Requirements
- R1: While `rst` is high at a rising clock edge, the position and the partial parity return to their start values, and `word_done` and `odd_parity` are 0 during any cycle in which `rst` is high, whatever the data inputs do.
- R2: `word_done` is 1 in exactly the cycle that presents the fourth accepted bit of a word (with `bit_valid` high), and 0 in every other cycle.
- R3: `odd_parity` is 0 whenever `word_done` is 0, so it stays 0 for the first three bits of each word.
- R4: In the cycle with `word_done` high, `odd_parity` equals the XOR of the four accepted bits of the word, counting the bit presented in that same cycle (1 means an odd count of ones).
- R5: A cycle with `bit_valid` low changes neither the position nor the partial parity, drives both outputs to 0, and the value on `bit_in` in that cycle has no effect on any later result.
- R6: The bit accepted directly after a word's fourth bit is the first bit of a new word, whose parity starts from zero, with no idle cycle required between words.
- R7: Asserting `rst` in the middle of a word discards the bits already accepted, so the next accepted bit is treated as the first bit of a fresh word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | High when `bit_in` carries a bit to be accepted this cycle |
| bit_in | input | 1 | Serial data bit |
| word_done | output | 1 | High in the cycle that presents the last bit of a word |
| odd_parity | output | 1 | Odd-ones result for the word; valid only while `word_done` is high |

## Verification
The hardest case to reach is a stall that falls just before the fourth bit, while the data line carries a value that would flip the result if it were accepted. A stall in that spot must not move the end-of-word cycle or change the parity. The stimulus sends every one of the sixteen possible words back to back. It inserts stalls at positions that shift from word to word, and during each stall it drives the inverse of the next real bit. This puts a stall with misleading data in front of every bit position, including the last. A reset applied after part of a word has gone in, followed by a word whose expected parity differs from the mixed result, shows whether the partial state was kept.

// File: rtl/swp_pkg.sv
package swp_pkg;
  // Default number of bits that make up one framed word.
  localparam int unsigned SWP_WORD_BITS = 4;

  // Width needed to index a bit position within a word of the given length.
  function automatic int unsigned pos_width(input int unsigned len);
    return (len <= 2) ? 1 : $clog2(len);
  endfunction
endpackage

// File: rtl/swp_position.sv
module swp_position #(
  parameter int unsigned LEN = swp_pkg::SWP_WORD_BITS,
  localparam int unsigned PW = swp_pkg::pos_width(LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [PW-1:0] pos,
  output logic          at_last
);
  localparam logic [PW-1:0] LAST_POS = PW'(LEN - 1);

  assign at_last = (pos == LAST_POS);

  always_ff @(posedge clk) begin
    if (rst)
      pos <= '0;
    else if (step)
      pos <= at_last ? '0 : pos + 1'b1;
  end

  // R5: a stalled cycle leaves the position where it was
  p_pos_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(pos));

  // R6: the word boundary takes the position back to the start
  p_pos_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (step && at_last) |=> (pos == '0));

  // R2: an accepted bit that is not the last moves exactly one place forward
  p_pos_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (step && !at_last) |=> (pos == $past(pos) + 1'b1));
endmodule

// File: rtl/swp_parity_acc.sv
module swp_parity_acc (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic clear,
  input  logic din,
  output logic acc,
  output logic result
);
  // Parity including the bit presented this cycle (Mealy view).
  assign result = acc ^ din;

  always_ff @(posedge clk) begin
    if (rst)
      acc <= 1'b0;
    else if (step)
      acc <= clear ? 1'b0 : result;
  end

  // R5: without an accepted bit the stored parity does not move
  p_acc_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(acc));

  // R6: closing a word leaves the stored parity at zero
  p_acc_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (step && clear) |=> !acc);
endmodule

// File: rtl/serial_word_parity.sv
module serial_word_parity #(
  parameter int unsigned WORD_LEN = swp_pkg::SWP_WORD_BITS
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic bit_in,
  output logic word_done,
  output logic odd_parity
);
  localparam int unsigned PW = swp_pkg::pos_width(WORD_LEN);

  logic [PW-1:0] pos;
  logic          at_last;
  logic          take;
  logic          acc;
  logic          par_now;

  assign take = bit_valid && !rst;

  swp_position #(.LEN(WORD_LEN)) u_pos (
    .clk     (clk),
    .rst     (rst),
    .step    (take),
    .pos     (pos),
    .at_last (at_last)
  );

  swp_parity_acc u_par (
    .clk    (clk),
    .rst    (rst),
    .step   (take),
    .clear  (at_last),
    .din    (bit_in),
    .acc    (acc),
    .result (par_now)
  );

  assign word_done  = take && at_last;
  assign odd_parity = word_done && par_now;

  // R3: a parity result never appears outside the end-of-word cycle
  p_par_needs_done_r3: assert property (@(posedge clk)
    odd_parity |-> word_done);

  // R5: a stalled cycle shows no end-of-word strobe
  p_stall_quiet_r5: assert property (@(posedge clk)
    !bit_valid |-> !word_done);

  // R1: reset keeps the strobe low
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |-> !word_done);

  // R2: two end-of-word strobes never fall in consecutive cycles for words longer than one bit
  p_done_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    (word_done && WORD_LEN > 1) |=> !word_done);
endmodule

// File: tb/tb_serial_word_parity.sv
module tb_serial_word_parity;
  localparam int CLK_P = 10;
  localparam int WATCHDOG_CYCLES = 5000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_valid = 1'b0;
  logic bit_in = 1'b0;
  logic word_done;
  logic odd_parity;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  serial_word_parity dut (
    .clk        (clk),
    .rst        (rst),
    .bit_valid  (bit_valid),
    .bit_in     (bit_in),
    .word_done  (word_done),
    .odd_parity (odd_parity)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG_CYCLES && !finished) begin
      failures = failures + 1;
      $display("FAIL R2 watchdog expired: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input logic act_d, input logic act_p,
                       input logic exp_d, input logic exp_p);
    checks = checks + 1;
    if (act_d !== exp_d || act_p !== exp_p) begin
      failures = failures + 1;
      $display("FAIL %s: actual done=%b odd=%b expected done=%b odd=%b",
               req, act_d, act_p, exp_d, exp_p);
    end
  endtask

  // Drive after the falling edge, sample mid low phase, then pass the rising edge.
  task automatic cycle(input logic r, input logic v, input logic b,
                       input logic exp_d, input logic exp_p, input string req);
    @(negedge clk);
    rst = r; bit_valid = v; bit_in = b;
    #(CLK_P/4);
    check(req, word_done, odd_parity, exp_d, exp_p);
    @(posedge clk);
  endtask

  initial begin
    // R1: outputs held low during reset even with a valid 1 on the line
    cycle(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R1 reset with valid data");
    cycle(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R1 reset second cycle");
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1 reset idle");

    // Exhaustive sweep of all 16 words, back to back, with shifting stalls.
    for (int w = 0; w < 16; w++) begin
      for (int i = 0; i < 4; i++) begin
        logic b;
        b = 1'(w >> (3 - i));
        if (((w + i) % 3) == 0)
          // R5: stall carrying the inverse bit is ignored
          cycle(1'b0, 1'b0, ~b, 1'b0, 1'b0, "R5 stall ignored");
        if (i < 3)
          cycle(1'b0, 1'b1, b, 1'b0, 1'b0, "R3 no result before last bit");
        else
          // R2 R4 R6: end strobe and parity of this word, next word starts clean
          cycle(1'b0, 1'b1, b, 1'b1, ^(4'(w)), "R4 word parity on fourth bit");
      end
    end

    // R6: strictly back to back words with no stalls
    for (int w = 0; w < 16; w += 5) begin
      for (int i = 0; i < 4; i++) begin
        logic b;
        b = 1'(w >> (3 - i));
        cycle(1'b0, 1'b1, b, (i == 3), (i == 3) && ^(4'(w)),
              (i == 3) ? "R6 back-to-back word end" : "R2 back-to-back mid word");
      end
    end

    // R7: partial word, reset, then word 0001 must give odd parity on its 4th bit
    cycle(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R7 partial bit 1");
    cycle(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R7 partial bit 2");
    cycle(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R1 R7 mid-word reset");
    cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R7 fresh bit 1");
    cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R7 fresh bit 2");
    cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R7 fresh bit 3");
    cycle(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R7 fresh word end");

    // R5: long stall just before the last bit
    cycle(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R5 pre-stall bit 1");
    cycle(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R5 pre-stall bit 2");
    cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R5 pre-stall bit 3");
    for (int k = 0; k < 5; k++)
      cycle(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R5 long stall");
    cycle(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R5 word end after stall");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule